// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Nesting

This block collects a parameterised set of external interrupt lines for one processor. Each line is latched as pending, either while the line is high or on its rising edge, and carries a programmable 8-bit priority where a smaller number means more urgent. A registered arbiter selects the most urgent pending, enabled line. It filters that line through a priority mask and compares it with the priority of the interrupt currently being serviced. It then raises a single interrupt request to the processor.

Software reaches the block through a plain register read/write port with two 4 KB regions. The processor-side region holds the enable, the mask, the acknowledge register, the end-of-interrupt register and the highest-pending register. The second region, starting at offset 0x1000, holds the global enable, the per-line enables, the trigger modes, the priorities and the pending and active views. Reading the acknowledge register makes the selected interrupt the running one. Writing its ID to the end-of-interrupt register retires it. The block keeps, for every interrupt, the ID that was running when it was taken. A retire therefore returns to the interrupted level, and interrupts can nest to any depth.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, cpu_irq is 0. Highest-pending (0x018) and running ID (0x014) read 1023, running priority (0x008) reads 0x100 and the mask (0x004) reads 0xF0. Both enables (0x000 bit 0, 0x1000 bit 0) read 0. Pending (0x1200) and active (0x1300) read 0.
- R2: External line n is reported and acknowledged as interrupt ID n+32.
- R3: While either the processor enable (0x000 bit 0) or the global enable (0x1000 bit 0) is 0, highest-pending reads 1023 and cpu_irq is 0.
- R4: Among lines that are pending and enabled (0x1100 bit n), the winner is the one with the numerically smallest priority (0x1400+4n, bits 7:0). On a tie the lowest line wins.
- R5: A winner whose priority is numerically greater than the mask is not reported: highest-pending reads 1023 and cpu_irq is 0. A priority equal to the mask is reported.
- R6: cpu_irq is 1 only when the reported priority is strictly smaller than the running priority. Highest-pending still shows the winner otherwise.
- R7: A read of 0x00C while cpu_irq is 1 returns the highest-pending ID. That interrupt becomes running with its own priority as the running priority, and cpu_irq is 0 on the next cycle. A read while cpu_irq is 0 returns 1023 and changes nothing.
- R8: With trigger bit n (0x1C00) at 0, line n is level-sensitive: it is pending while high and not active, and it is cleared at acknowledge. With the bit at 1, a rising edge latches pending (also while active), and acknowledge clears it.
- R9: A write to 0x010 whose bits 9:0 equal the running ID retires it. The running ID returns to the one that was running when it was acknowledged, and the running priority returns to that interrupt's priority (0x100 for 1023).
- R10: An end-of-interrupt write is ignored when the running ID is 1023 or when its ID differs from the running ID.
- R11: Arbitration is registered. A change of pending state, enables, mask or running priority reaches cpu_irq and highest-pending on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_EXT | External interrupt lines, line n is ID n+32 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acknowledge side effect) |
| reg_addr | input | 13 | Byte address, bit 12 selects the global region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A wrong running ID or a corrupted nesting link does not show up at once. It appears only at the next retire, when the running ID read at 0x014 lands on the wrong level and an equal-priority request stays masked or fires. For that reason the nesting test retires two levels and reads the running ID after each retire. A wrong pending or active bit shows within two edges as a wrong highest-pending ID or a wrong cpu_irq level. The tests read pending and active directly so that such a fault is caught one edge after acknowledge.

// File: rtl/nic_pkg.sv
package nic_pkg;
   localparam int ID_W     = 10;
   typedef logic [ID_W-1:0] irq_id_t;
   localparam irq_id_t NO_IRQ = 10'd1023;
   localparam int EXT_BASE = 32;

   localparam int ADDR_W = 13;
   typedef logic [ADDR_W-1:0] reg_addr_t;

   // processor-side region
   localparam reg_addr_t A_CPU_CTRL = 13'h0000;
   localparam reg_addr_t A_CPU_MASK = 13'h0004;
   localparam reg_addr_t A_CPU_RPRI = 13'h0008;
   localparam reg_addr_t A_CPU_ACK  = 13'h000C;
   localparam reg_addr_t A_CPU_EOI  = 13'h0010;
   localparam reg_addr_t A_CPU_RUN  = 13'h0014;
   localparam reg_addr_t A_CPU_HPND = 13'h0018;
   // global region
   localparam reg_addr_t A_GLB_CTRL = 13'h1000;
   localparam reg_addr_t A_GLB_EN   = 13'h1100;
   localparam reg_addr_t A_GLB_PEND = 13'h1200;
   localparam reg_addr_t A_GLB_ACT  = 13'h1300;
   localparam reg_addr_t A_GLB_PRIO = 13'h1400;
   localparam reg_addr_t A_GLB_TRIG = 13'h1C00;
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
   import nic_pkg::*;
#(
   parameter int N_EXT    = 8,
   parameter int PRIO_W   = 8,
   parameter int MASK_RST = 'hF0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  reg_addr_t                      addr,
   input  logic [31:0]                    wdata,
   output logic                           glb_en,
   output logic                           cpu_en,
   output logic [PRIO_W-1:0]              mask,
   output logic [N_EXT-1:0]               line_en,
   output logic [N_EXT-1:0]               trig_edge,
   output logic [N_EXT-1:0][PRIO_W-1:0]   prio
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en    <= 1'b0;
         cpu_en    <= 1'b0;
         mask      <= PRIO_W'(MASK_RST);
         line_en   <= '0;
         trig_edge <= '0;
      end else if (wr_en) begin
         case (addr)
            A_GLB_CTRL: glb_en    <= wdata[0];
            A_CPU_CTRL: cpu_en    <= wdata[0];
            A_CPU_MASK: mask      <= wdata[PRIO_W-1:0];
            A_GLB_EN:   line_en   <= wdata[N_EXT-1:0];
            A_GLB_TRIG: trig_edge <= wdata[N_EXT-1:0];
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < N_EXT; i++) begin : g_prio
      localparam reg_addr_t SLOT = A_GLB_PRIO + reg_addr_t'(4 * i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio[i] <= '0;
         else if (wr_en && addr == SLOT)
            prio[i] <= wdata[PRIO_W-1:0];
      end
   end
endmodule

// File: rtl/nic_line_state.sv
module nic_line_state #(
   parameter int N_EXT   = 8,
   parameter int LINE_IW = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_EXT-1:0]   lines,
   input  logic [N_EXT-1:0]   trig_edge,
   input  logic               take,
   input  logic [LINE_IW-1:0] take_line,
   input  logic               retire,
   input  logic [LINE_IW-1:0] retire_line,
   output logic [N_EXT-1:0]   pend,
   output logic [N_EXT-1:0]   act
);
   for (genvar i = 0; i < N_EXT; i++) begin : g_line
      logic prev_q;
      logic take_here, ret_here, act_nxt, rise;
      always_comb begin
         take_here = take && (take_line == LINE_IW'(i));
         ret_here  = retire && (retire_line == LINE_IW'(i));
         act_nxt   = take_here | (act[i] & ~ret_here);
         rise      = lines[i] & ~prev_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q  <= 1'b0;
            pend[i] <= 1'b0;
            act[i]  <= 1'b0;
         end else begin
            prev_q <= lines[i];
            act[i] <= act_nxt;
            if (trig_edge[i])
               pend[i] <= (pend[i] & ~take_here) | rise;
            else
               pend[i] <= lines[i] & ~act_nxt;
         end
      end
   end
endmodule

// File: rtl/nic_pick.sv
module nic_pick
   import nic_pkg::*;
#(
   parameter int N_EXT   = 8,
   parameter int PRIO_W  = 8,
   parameter int LINE_IW = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          glb_en,
   input  logic                          cpu_en,
   input  logic [PRIO_W-1:0]             mask,
   input  logic [N_EXT-1:0]              pend,
   input  logic [N_EXT-1:0]              line_en,
   input  logic [N_EXT-1:0][PRIO_W-1:0]  prio,
   input  logic [PRIO_W:0]               run_prio,
   input  logic                          take,
   output irq_id_t                       hp_id,
   output logic                          irq_q
);
   localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

   logic [PRIO_W:0]    best;
   logic [LINE_IW-1:0] best_idx;
   logic               shown;
   irq_id_t            hp_d;
   logic               irq_d;

   always_comb begin
      best     = IDLE;
      best_idx = '0;
      for (int i = 0; i < N_EXT; i++) begin
         if (pend[i] && line_en[i] && ({1'b0, prio[i]} < best)) begin
            best     = {1'b0, prio[i]};
            best_idx = LINE_IW'(i);
         end
      end
      shown = glb_en && cpu_en && (best <= {1'b0, mask});
      hp_d  = shown ? (irq_id_t'(EXT_BASE) + irq_id_t'(best_idx)) : NO_IRQ;
      irq_d = shown && (best < run_prio);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hp_id <= NO_IRQ;
         irq_q <= 1'b0;
      end else begin
         hp_id <= hp_d;
         irq_q <= take ? 1'b0 : irq_d;
      end
   end
endmodule

// File: rtl/nic_nest_track.sv
module nic_nest_track
   import nic_pkg::*;
#(
   parameter int N_EXT   = 8,
   parameter int PRIO_W  = 8,
   parameter int LINE_IW = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_EXT-1:0][PRIO_W-1:0]  prio,
   input  logic                          take,
   input  irq_id_t                       take_id,
   input  logic                          eoi_wr,
   input  irq_id_t                       eoi_id,
   output irq_id_t                       run_id,
   output logic [PRIO_W:0]               run_prio,
   output logic                          retire,
   output logic [LINE_IW-1:0]            retire_line,
   output logic [LINE_IW-1:0]            take_line
);
   localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

   irq_id_t            link [N_EXT];
   irq_id_t            back_id;
   logic [LINE_IW-1:0] back_line;

   always_comb begin
      take_line   = LINE_IW'(take_id - irq_id_t'(EXT_BASE));
      retire_line = LINE_IW'(run_id - irq_id_t'(EXT_BASE));
      retire      = eoi_wr && !take && (run_id != NO_IRQ) && (eoi_id == run_id);
      back_id     = link[retire_line];
      back_line   = LINE_IW'(back_id - irq_id_t'(EXT_BASE));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_id   <= NO_IRQ;
         run_prio <= IDLE;
      end else if (take) begin
         run_id   <= take_id;
         run_prio <= {1'b0, prio[take_line]};
      end else if (retire) begin
         run_id   <= back_id;
         run_prio <= (back_id == NO_IRQ) ? IDLE : {1'b0, prio[back_line]};
      end
   end

   for (genvar i = 0; i < N_EXT; i++) begin : g_link
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            link[i] <= NO_IRQ;
         else if (take && take_line == LINE_IW'(i))
            link[i] <= run_id;
      end
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int N_EXT    = 8,
   parameter int PRIO_W   = 8,
   parameter int MASK_RST = 'hF0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_EXT-1:0]    irq_lines,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                cpu_irq
);
   localparam int LINE_IW = (N_EXT > 1) ? $clog2(N_EXT) : 1;

   if (N_EXT < 1 || N_EXT > 32) begin : g_bad_lines
      $error("N_EXT must lie in 1..32");
   end
   if (PRIO_W != 8) begin : g_bad_prio
      $error("PRIO_W must be 8");
   end

   logic                          glb_en, cpu_en;
   logic [PRIO_W-1:0]             mask;
   logic [N_EXT-1:0]              line_en, trig_edge, pend, act;
   logic [N_EXT-1:0][PRIO_W-1:0]  prio;
   irq_id_t                       hp_id, run_id;
   logic [PRIO_W:0]               run_prio;
   logic                          irq_q, take, eoi_wr, retire;
   logic [LINE_IW-1:0]            take_line, retire_line;

   assign take    = reg_rd && !reg_wr && (reg_addr == A_CPU_ACK) && irq_q;
   assign eoi_wr  = reg_wr && (reg_addr == A_CPU_EOI);
   assign cpu_irq = irq_q;

   nic_cfg_regs #(.N_EXT(N_EXT), .PRIO_W(PRIO_W), .MASK_RST(MASK_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .glb_en(glb_en), .cpu_en(cpu_en), .mask(mask), .line_en(line_en),
      .trig_edge(trig_edge), .prio(prio));

   nic_line_state #(.N_EXT(N_EXT), .LINE_IW(LINE_IW)) u_lines (
      .clk(clk), .rst_n(rst_n), .lines(irq_lines), .trig_edge(trig_edge),
      .take(take), .take_line(take_line), .retire(retire), .retire_line(retire_line),
      .pend(pend), .act(act));

   nic_pick #(.N_EXT(N_EXT), .PRIO_W(PRIO_W), .LINE_IW(LINE_IW)) u_pick (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cpu_en(cpu_en), .mask(mask),
      .pend(pend), .line_en(line_en), .prio(prio), .run_prio(run_prio),
      .take(take), .hp_id(hp_id), .irq_q(irq_q));

   nic_nest_track #(.N_EXT(N_EXT), .PRIO_W(PRIO_W), .LINE_IW(LINE_IW)) u_nest (
      .clk(clk), .rst_n(rst_n), .prio(prio), .take(take), .take_id(hp_id),
      .eoi_wr(eoi_wr), .eoi_id(reg_wdata[ID_W-1:0]), .run_id(run_id),
      .run_prio(run_prio), .retire(retire), .retire_line(retire_line),
      .take_line(take_line));

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         case (reg_addr)
            A_CPU_CTRL: reg_rdata = 32'(cpu_en);
            A_CPU_MASK: reg_rdata = 32'(mask);
            A_CPU_RPRI: reg_rdata = 32'(run_prio);
            A_CPU_ACK:  reg_rdata = 32'(take ? hp_id : NO_IRQ);
            A_CPU_RUN:  reg_rdata = 32'(run_id);
            A_CPU_HPND: reg_rdata = 32'(hp_id);
            A_GLB_CTRL: reg_rdata = 32'(glb_en);
            A_GLB_EN:   reg_rdata = 32'(line_en);
            A_GLB_PEND: reg_rdata = 32'(pend);
            A_GLB_ACT:  reg_rdata = 32'(act);
            A_GLB_TRIG: reg_rdata = 32'(trig_edge);
            default: begin
               for (int i = 0; i < N_EXT; i++)
                  if (reg_addr == A_GLB_PRIO + reg_addr_t'(4 * i))
                     reg_rdata = 32'(prio[i]);
            end
         endcase
      end
   end
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk
   import nic_pkg::*;
#(
   parameter int N_EXT  = 8,
   parameter int PRIO_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_irq,
   input irq_id_t            hp_id,
   input irq_id_t            run_id,
   input logic [PRIO_W:0]    run_prio,
   input logic               take,
   input logic               eoi_wr,
   input logic               glb_en,
   input logic               cpu_en,
   input logic [N_EXT-1:0]   pend,
   input logic [N_EXT-1:0]   act,
   input logic [N_EXT-1:0]   trig_edge
);
   localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

   p_idle_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run_id == NO_IRQ |-> run_prio == IDLE);

   p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(glb_en && cpu_en) |=> !cpu_irq);

   p_irq_has_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> hp_id != NO_IRQ);

   p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !cpu_irq);

   p_ack_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> run_id == $past(hp_id));

   p_level_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & act & ~$past(trig_edge)) == '0);

   p_eoi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !take && run_id == NO_IRQ) |=> run_id == NO_IRQ);
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.N_EXT(N_EXT), .PRIO_W(PRIO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .hp_id(hp_id), .run_id(run_id),
   .run_prio(run_prio), .take(take), .eoi_wr(eoi_wr), .glb_en(glb_en),
   .cpu_en(cpu_en), .pend(pend), .act(act), .trig_edge(trig_edge));

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] lines = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [12:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cpu_irq;
   int checks = 0, errors = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   nest_irq_ctrl #(.N_EXT(N)) uut (
      .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq));

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h exp %0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [12:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [12:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [12:0] a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic do_reset();
      lines = '0;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
   endtask

   task automatic cfg_on();
      wr(13'h1000, 1);
      wr(13'h0000, 1);
      wr(13'h0004, 32'hFF);
      wr(13'h1100, 32'hFF);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 cpu_irq", 32'(cpu_irq), 0);
      rd_chk("R1 hpend", 13'h0018, 1023);
      rd_chk("R1 run id", 13'h0014, 1023);
      rd_chk("R1 run prio", 13'h0008, 32'h100);
      rd_chk("R1 mask", 13'h0004, 32'hF0);
      rd_chk("R1 cpu en", 13'h0000, 0);
      rd_chk("R1 glb en", 13'h1000, 0);
      rd_chk("R1 pend", 13'h1200, 0);
      rd_chk("R1 act", 13'h1300, 0);
   endtask

   task automatic t_gate();
      do_reset();
      wr(13'h1400 + 13'(4*3), 32'h40);
      wr(13'h1100, 32'hFF);
      lines[3] = 1'b1;
      idle(3);
      rd_chk("R8 level pend", 13'h1200, 32'h08);
      rd_chk("R3 both off", 13'h0018, 1023);
      chk("R3 irq both off", 32'(cpu_irq), 0);
      wr(13'h1000, 1);
      idle(3);
      rd_chk("R3 cpu off", 13'h0018, 1023);
      chk("R3 irq cpu off", 32'(cpu_irq), 0);
      wr(13'h0000, 1);
      idle(3);
      rd_chk("R2 id 35", 13'h0018, 35);
      chk("R11 irq on", 32'(cpu_irq), 1);
   endtask

   task automatic t_mask();
      wr(13'h0004, 32'h3F);
      idle(3);
      rd_chk("R5 above mask", 13'h0018, 1023);
      chk("R5 irq above mask", 32'(cpu_irq), 0);
      wr(13'h0004, 32'h40);
      idle(3);
      rd_chk("R5 equal mask", 13'h0018, 35);
      chk("R5 irq equal mask", 32'(cpu_irq), 1);
   endtask

   task automatic t_arb();
      do_reset();
      cfg_on();
      wr(13'h1400 + 13'(4*1), 32'h50);
      wr(13'h1400 + 13'(4*4), 32'h30);
      wr(13'h1400 + 13'(4*6), 32'h30);
      lines = 8'b0101_0010;
      idle(3);
      rd_chk("R4 tie low line", 13'h0018, 36);
      wr(13'h1400 + 13'(4*2), 32'h10);
      lines[2] = 1'b1;
      idle(3);
      rd_chk("R4 lowest value", 13'h0018, 34);
      wr(13'h1100, 32'hFB);
      idle(3);
      rd_chk("R4 disabled line", 13'h0018, 36);
   endtask

   task automatic t_ack_level();
      do_reset();
      cfg_on();
      wr(13'h1400 + 13'(4*2), 32'h80);
      lines[2] = 1'b1;
      idle(3);
      chk("R7 irq before ack", 32'(cpu_irq), 1);
      rd_chk("R7 ack id", 13'h000C, 34);
      chk("R7 irq after ack", 32'(cpu_irq), 0);
      idle(2);
      chk("R7 irq stays low", 32'(cpu_irq), 0);
      rd_chk("R7 run id", 13'h0014, 34);
      rd_chk("R7 run prio", 13'h0008, 32'h80);
      rd_chk("R8 level cleared", 13'h1200, 0);
      rd_chk("R8 active", 13'h1300, 32'h04);
      rd_chk("R7 ack none", 13'h000C, 1023);
      rd_chk("R7 run unchanged", 13'h0014, 34);
      wr(13'h0010, 34);
      idle(3);
      rd_chk("R9 back idle", 13'h0014, 1023);
      rd_chk("R9 idle prio", 13'h0008, 32'h100);
      chk("R8 repend after eoi", 32'(cpu_irq), 1);
      lines[2] = 1'b0;
      idle(3);
      chk("R8 level drop", 32'(cpu_irq), 0);
   endtask

   task automatic t_nest();
      do_reset();
      cfg_on();
      wr(13'h1400 + 13'(4*0), 32'h60);
      wr(13'h1400 + 13'(4*7), 32'h60);
      wr(13'h1400 + 13'(4*5), 32'h20);
      lines[0] = 1'b1;
      idle(3);
      rd_chk("R7 ack 32", 13'h000C, 32);
      lines[7] = 1'b1;
      idle(3);
      rd_chk("R6 equal shown", 13'h0018, 39);
      chk("R6 equal no irq", 32'(cpu_irq), 0);
      lines[5] = 1'b1;
      idle(3);
      chk("R6 lower preempts", 32'(cpu_irq), 1);
      rd_chk("R6 ack 37", 13'h000C, 37);
      lines[5] = 1'b0;
      rd_chk("R9 nested run", 13'h0014, 37);
      wr(13'h0010, 37);
      idle(3);
      rd_chk("R9 restore id", 13'h0014, 32);
      rd_chk("R9 restore prio", 13'h0008, 32'h60);
      chk("R6 still blocked", 32'(cpu_irq), 0);
      wr(13'h0010, 32);
      idle(3);
      rd_chk("R9 unwind idle", 13'h0014, 1023);
   endtask

   task automatic t_eoi_ignore();
      do_reset();
      cfg_on();
      wr(13'h0010, 32);
      idle(2);
      rd_chk("R10 idle eoi", 13'h0014, 1023);
      rd_chk("R10 idle prio", 13'h0008, 32'h100);
      wr(13'h1400 + 13'(4*1), 32'h10);
      lines[1] = 1'b1;
      idle(3);
      rd_chk("R7 ack 33", 13'h000C, 33);
      wr(13'h0010, 40);
      idle(2);
      rd_chk("R10 wrong id", 13'h0014, 33);
      wr(13'h0010, 32'hFFFF_FC00 | 33);
      idle(2);
      rd_chk("R9 low ten bits", 13'h0014, 1023);
   endtask

   task automatic t_edge();
      do_reset();
      cfg_on();
      wr(13'h1C00, 32'h10);
      wr(13'h1400 + 13'(4*4), 32'h10);
      lines[4] = 1'b1;
      idle(1);
      lines[4] = 1'b0;
      idle(3);
      rd_chk("R8 edge latched", 13'h1200, 32'h10);
      rd_chk("R8 edge ack", 13'h000C, 36);
      idle(1);
      rd_chk("R8 edge cleared", 13'h1200, 0);
      lines[4] = 1'b1;
      idle(1);
      lines[4] = 1'b0;
      idle(2);
      rd_chk("R8 edge while active", 13'h1200, 32'h10);
      wr(13'h0010, 36);
      idle(3);
      chk("R8 edge refire", 32'(cpu_irq), 1);
      rd_chk("R8 edge hpend", 13'h0018, 36);
   endtask

   initial begin
      t_reset();
      t_gate();
      t_mask();
      t_arb();
      t_ack_level();
      t_nest();
      t_eoi_ignore();
      t_edge();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog got hung exp finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule